// File: doc/BRIEF.md
# Indirect Addressing Pointer Unit

This block sits between the core of a small accumulator-style processor and its byte-wide data memory. It holds three 16-bit pointer registers and, for each of them, a small window of virtual registers inside the special-function region of the 12-bit data address space. When the core reads or writes one of these virtual registers, the unit replaces the address with one taken from the selected pointer, forwards the access to the data memory, and steps the pointer where the chosen mode asks for it. Five modes exist per pointer: plain, read-then-increment, read-then-decrement, increment-then-read, and pointer plus a signed offset from the working register.

The working register (an 8-bit accumulator) lives in this unit and is also reachable as an ordinary data location. Both bytes of each pointer can be read and written directly. Accesses that match none of these locations go to the data memory unchanged. Every access completes in one cycle: the address and the read data are combinational, and the register updates take effect at the next rising clock edge.

Top module: `ptr_access_unit`

## Requirements
- R1: After reset, all three pointers and the working register read as zero.
- R2: The window of pointer n starts at 0xFD0 + 8*n. Inside it, offset 0 is plain, 1 is post-increment, 2 is post-decrement, 3 is pre-increment, 4 is plus-working-register, 5 is the low pointer byte and 6 is the high pointer byte. A write to one pointer's window does not change the other pointers.
- R3: A plain access uses the pointer as the memory address and leaves the pointer unchanged.
- R4: A post-increment access uses the current pointer as the address, and the pointer is one higher afterwards.
- R5: A post-decrement access uses the current pointer as the address, and the pointer is one lower afterwards. Decrementing 0x0000 gives 0xFFFF.
- R6: A pre-increment access first adds one to the pointer, then uses the new value as the address.
- R7: A plus-working-register access uses the pointer plus the sign-extended working register as the address (0xFE adds -2, 0x7F adds +127) and leaves the pointer unchanged.
- R8: Address 0xFE8 reads and writes the working register and never reaches the data memory.
- R9: The low and high bytes of each pointer can be written and read back directly. These accesses do not reach the data memory.
- R10: Only the low 12 bits of a computed address drive the memory. Pointer arithmetic wraps modulo 2^16, so incrementing 0xFFFF gives 0x0000.
- R11: If an indirect access resolves (in its low 12 bits) to offsets 0 to 4 of any pointer window, a read returns 0x00, a write is dropped, no memory strobe is raised and no pointer changes.
- R12: Any other address, including offset 7 of a window, goes to the data memory unchanged, and read data comes back from the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Core access valid this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 12 | Data address issued by the core |
| cpu_wdata | input | 8 | Write data from the core |
| cpu_rdata | output | 8 | Read data to the core |
| mem_re | output | 1 | Data memory read strobe |
| mem_we | output | 1 | Data memory write strobe |
| mem_addr | output | 12 | Data memory address |
| mem_wdata | output | 8 | Data memory write data |
| mem_rdata | input | 8 | Data memory read data (same cycle) |
| w_q | output | 8 | Current working register value |

## Verification
Each mode is first run with the pointer at a mid-range value. Back-to-back post-increment writes followed by post-decrement reads show whether the step happens before or after the address is taken, and whether the two modes cancel out. The plus-working-register mode is tried with a negative and a positive offset, which tells sign extension apart from zero extension. Pointers at 0x0000 and 0xFFFF show 16-bit wrap and 12-bit address truncation. Pointers aimed at a virtual slot, with both a zero and a non-zero upper nibble, show that self-references are dropped and that the check uses only the low 12 bits.

// File: rtl/ptr_pkg.sv
// Shared definitions for the indirect addressing pointer unit.
// Assumes every pointer window is eight addresses wide and starts on an
// eight-aligned address, so the low three address bits select the slot.
package ptr_pkg;

    localparam int SLOTS_PER_PTR = 8;

    // Slot encoding inside one pointer window (the offset from the window base)
    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_POSTINC = 3'd1,
        AM_POSTDEC = 3'd2,
        AM_PREINC  = 3'd3,
        AM_PLUSW   = 3'd4,
        AM_PTRLO   = 3'd5,
        AM_PTRHI   = 3'd6,
        AM_SPARE   = 3'd7
    } slot_e;

endpackage

// File: rtl/ptr_decode.sv
// Decodes a core address against the pointer windows.
// Output: whether the address falls in any window, which pointer it
// selects and which slot. Assumes PTR_BASE is eight-aligned and that the
// windows end below the top of the address space.
module ptr_decode
    import ptr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NPTR     = 3,
    parameter int IDX_W    = 2,
    parameter int PTR_BASE = 'hFD0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output slot_e             slot
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PTR_BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(SLOTS_PER_PTR * NPTR);

    logic [ADDR_W-1:0] off;

    // Offset from the first window; below-base addresses wrap to large values
    always_comb begin
        off  = addr - BASE_A;
        hit  = (off < SPAN_A);
        idx  = off[IDX_W+2:3];
        slot = slot_e'(off[2:0]);
    end

endmodule

// File: rtl/ptr_addr_gen.sv
// Computes the effective memory address and the pointer's next value for
// one access mode. Purely combinational. Assumes the working register is
// DATA_W bits wide and narrower than ADDR_W; it is sign-extended.
module ptr_addr_gen
    import ptr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8,
    parameter int PTR_W  = 16
) (
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DATA_W-1:0] w,
    input  slot_e             slot,
    output logic [ADDR_W-1:0] eff,
    output logic [PTR_W-1:0]  nxt,
    output logic              moves
);

    logic [PTR_W-1:0]  inc;
    logic [PTR_W-1:0]  dec;
    logic [ADDR_W-1:0] w_sext;

    // Full-width step values and the signed offset
    always_comb begin
        inc    = ptr + PTR_W'(1);
        dec    = ptr - PTR_W'(1);
        w_sext = {{(ADDR_W-DATA_W){w[DATA_W-1]}}, w};
    end

    // Per-mode address choice and pointer update rule
    always_comb begin
        eff   = ptr[ADDR_W-1:0];
        nxt   = ptr;
        moves = 1'b0;
        case (slot)
            AM_POSTINC: begin nxt = inc; moves = 1'b1; end
            AM_POSTDEC: begin nxt = dec; moves = 1'b1; end
            AM_PREINC:  begin eff = inc[ADDR_W-1:0]; nxt = inc; moves = 1'b1; end
            AM_PLUSW:   eff = ptr[ADDR_W-1:0] + w_sext;
            default:    ;
        endcase
    end

endmodule

// File: rtl/ptr_file.sv
// Holds the pointer registers. One register per pointer, each loaded
// either by a mode step or by a direct byte write. Assumes the two
// never target the same cycle (one core access per cycle) and that
// PTR_W is exactly two DATA_W bytes.
module ptr_file #(
    parameter int NPTR   = 3,
    parameter int IDX_W  = 2,
    parameter int PTR_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [IDX_W-1:0]            idx,
    input  logic                        upd_en,
    input  logic [PTR_W-1:0]            upd_val,
    input  logic                        byte_we,
    input  logic                        byte_hi,
    input  logic [DATA_W-1:0]           byte_wdata,
    output logic [NPTR-1:0][PTR_W-1:0]  ptr_q
);

    for (genvar i = 0; i < NPTR; i++) begin : g_ptr
        logic [PTR_W-1:0] q;

        // Pointer i: reset, mode step, or byte load
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (idx == IDX_W'(i)) begin
                if (upd_en) begin
                    q <= upd_val;
                end else if (byte_we) begin
                    if (byte_hi) q[PTR_W-1:DATA_W] <= byte_wdata;
                    else         q[DATA_W-1:0]     <= byte_wdata;
                end
            end
        end

        assign ptr_q[i] = q;
    end

endmodule

// File: rtl/ptr_access_unit.sv
// Top of the indirect addressing pointer unit. Decodes each core access.
// A virtual indirect slot is turned into a data memory access at the
// address computed from the pointer. The working register and the pointer
// bytes are served locally, and anything else is passed through. All
// paths are single-cycle: mem_rdata must be valid in the same cycle as
// mem_addr. Assumes the working register address lies outside the
// pointer windows.
module ptr_access_unit
    import ptr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int PTR_W     = 16,
    parameter int NPTR      = 3,
    parameter int PTR_BASE  = 'hFD0,
    parameter int WREG_ADDR = 'hFE8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] w_q
);

    localparam int IDX_W = (NPTR > 1) ? $clog2(NPTR) : 1;
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PTR_BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(SLOTS_PER_PTR * NPTR);
    localparam logic [ADDR_W-1:0] WREG_A = ADDR_W'(WREG_ADDR);

    logic [NPTR-1:0][PTR_W-1:0] ptr_q;
    logic [DATA_W-1:0]          w_reg;
    logic                       a_hit;
    logic [IDX_W-1:0]           a_idx;
    slot_e                      a_slot;
    logic [PTR_W-1:0]           cur;
    logic [ADDR_W-1:0]          eff;
    logic [PTR_W-1:0]           nxt;
    logic                       moves;
    logic [ADDR_W-1:0]          eoff;
    logic                       is_ind;
    logic                       is_pb;
    logic                       is_w;
    logic                       blocked;
    logic                       fwd;

    ptr_decode #(
        .ADDR_W   (ADDR_W),
        .NPTR     (NPTR),
        .IDX_W    (IDX_W),
        .PTR_BASE (PTR_BASE)
    ) u_dec (
        .addr (cpu_addr),
        .hit  (a_hit),
        .idx  (a_idx),
        .slot (a_slot)
    );

    // Select the pointer named by the decoded window
    always_comb begin
        cur = '0;
        for (int i = 0; i < NPTR; i++) begin
            if (a_idx == IDX_W'(i)) cur = ptr_q[i];
        end
    end

    ptr_addr_gen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PTR_W  (PTR_W)
    ) u_gen (
        .ptr   (cur),
        .w     (w_reg),
        .slot  (a_slot),
        .eff   (eff),
        .nxt   (nxt),
        .moves (moves)
    );

    // Classify the access and detect indirect self-references
    always_comb begin
        is_ind  = cpu_req && a_hit && (a_slot <= AM_PLUSW);
        is_pb   = cpu_req && a_hit && ((a_slot == AM_PTRLO) || (a_slot == AM_PTRHI));
        is_w    = cpu_req && (cpu_addr == WREG_A);
        eoff    = eff - BASE_A;
        blocked = is_ind && (eoff < SPAN_A) && (eoff[2:0] <= 3'd4);
        fwd     = cpu_req && !is_w && !is_pb && !blocked;
    end

    // Drive the data memory side
    always_comb begin
        mem_re    = fwd && !cpu_we;
        mem_we    = fwd && cpu_we;
        mem_addr  = is_ind ? eff : cpu_addr;
        mem_wdata = cpu_wdata;
    end

    // Return read data from the source that owns the address
    always_comb begin
        if (is_w)
            cpu_rdata = w_reg;
        else if (is_pb)
            cpu_rdata = (a_slot == AM_PTRHI) ? cur[PTR_W-1:DATA_W] : cur[DATA_W-1:0];
        else if (mem_re)
            cpu_rdata = mem_rdata;
        else
            cpu_rdata = '0;
    end

    ptr_file #(
        .NPTR   (NPTR),
        .IDX_W  (IDX_W),
        .PTR_W  (PTR_W),
        .DATA_W (DATA_W)
    ) u_file (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (a_idx),
        .upd_en     (is_ind && !blocked && moves),
        .upd_val    (nxt),
        .byte_we    (is_pb && cpu_we),
        .byte_hi    (a_slot == AM_PTRHI),
        .byte_wdata (cpu_wdata),
        .ptr_q      (ptr_q)
    );

    // Working register: loaded through its memory-mapped address
    always_ff @(posedge clk) begin
        if (!rst_n)
            w_reg <= '0;
        else if (is_w && cpu_we)
            w_reg <= cpu_wdata;
    end

    assign w_q = w_reg;

endmodule

// File: rtl/ptr_access_chk.sv
// Property checker for ptr_access_unit, attached through bind.
// Observes the core and memory ports plus the pointer register outputs.
module ptr_access_chk
    import ptr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    parameter int PTR_W     = 16,
    parameter int NPTR      = 3,
    parameter int PTR_BASE  = 'hFD0,
    parameter int WREG_ADDR = 'hFE8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cpu_req,
    input logic                       cpu_we,
    input logic [ADDR_W-1:0]          cpu_addr,
    input logic [DATA_W-1:0]          cpu_wdata,
    input logic                       mem_re,
    input logic                       mem_we,
    input logic [ADDR_W-1:0]          mem_addr,
    input logic [DATA_W-1:0]          w_q,
    input logic [NPTR-1:0][PTR_W-1:0] ptr_q
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PTR_BASE);
    localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(SLOTS_PER_PTR * NPTR);
    localparam logic [ADDR_W-1:0] WREG_A = ADDR_W'(WREG_ADDR);

    logic [ADDR_W-1:0] aoff;
    logic [ADDR_W-1:0] moff;
    logic              a_ind;
    logic              m_virt;

    // Whether the core address and the memory address are virtual slots
    always_comb begin
        aoff   = cpu_addr - BASE_A;
        moff   = mem_addr - BASE_A;
        a_ind  = (aoff < SPAN_A) && (aoff[2:0] <= 3'd4);
        m_virt = (moff < SPAN_A) && (moff[2:0] <= 3'd4);
    end

    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> (!mem_re && !mem_we));

    // R8
    wreg_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_addr == WREG_A) |-> (!mem_re && !mem_we));

    // R8
    wreg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_addr == WREG_A) |=> (w_q == $past(cpu_wdata)));

    // R3
    plain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_addr == BASE_A) |=> (ptr_q == $past(ptr_q)));

    // R4
    postinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_addr == BASE_A + ADDR_W'(1) && (mem_re || mem_we))
        |=> (ptr_q[0] == $past(ptr_q[0]) + PTR_W'(1)));

    // R11
    no_self_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && a_ind && (mem_re || mem_we)) |-> !m_virt);

endmodule

bind ptr_access_unit ptr_access_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PTR_W     (PTR_W),
    .NPTR      (NPTR),
    .PTR_BASE  (PTR_BASE),
    .WREG_ADDR (WREG_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .w_q       (w_q),
    .ptr_q     (ptr_q)
);

// File: tb/ptr_access_unit_tb_top.sv
// Scoreboard bench: driver tasks queue the expected result of each access,
// and a monitor on the falling edge pops and compares it.
module ptr_access_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req;
    logic        cpu_we;
    logic [11:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic [7:0]  cpu_rdata;
    logic        mem_re;
    logic        mem_we;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [7:0]  w_q;

    always #10 clk = ~clk;

    ptr_access_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .w_q       (w_q)
    );

    // Data memory model: asynchronous read, write on the rising edge
    logic [7:0] mem [0:4095];
    initial for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
    assign mem_rdata = mem[mem_addr];

    typedef struct {
        bit          rd;
        logic [7:0]  rdat;
        bit          mre;
        bit          mwe;
        logic [11:0] maddr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic access(input bit we, input logic [11:0] a, input logic [7:0] d,
                          input logic [7:0] rdat, input bit mre, input bit mwe,
                          input logic [11:0] ma, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        e.rd = !we; e.rdat = rdat; e.mre = mre; e.mwe = mwe; e.maddr = ma; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic rd(input logic [11:0] a, input logic [7:0] exp_d, input bit mre,
                      input logic [11:0] ma, input string tag);
        access(1'b0, a, 8'h00, exp_d, mre, 1'b0, ma, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d, input bit mwe,
                      input logic [11:0] ma, input string tag);
        access(1'b1, a, d, 8'h00, 1'b0, mwe, ma, tag);
    endtask

    task automatic idle();
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare each active access against the queued expectation
    always @(negedge clk) begin
        if (rst_n && cpu_req) begin
            if (q.size() == 0) begin
                check(1'b0, "SB", "unexpected access", 0, 1);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.rd) check(cpu_rdata == e.rdat, e.tag, "rdata", cpu_rdata, e.rdat);
                check(mem_re == e.mre, e.tag, "mem_re", mem_re, e.mre);
                check(mem_we == e.mwe, e.tag, "mem_we", mem_we, e.mwe);
                if (e.mre || e.mwe)
                    check(mem_addr == e.maddr, e.tag, "mem_addr", mem_addr, e.maddr);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(w_q == 8'h00, "R1", "w_q", w_q, 0);

        // R1: reset values through the byte and working register addresses
        rd(12'hFD5, 8'h00, 0, 0, "R1");
        rd(12'hFE6, 8'h00, 0, 0, "R1");
        rd(12'hFE8, 8'h00, 0, 0, "R1");
        rd(12'hFDD, 8'h00, 0, 0, "R1");
        // R9: direct pointer byte loads, pointer 0 = 0x0120
        wr(12'hFD5, 8'h20, 0, 0, "R9");
        wr(12'hFD6, 8'h01, 0, 0, "R9");
        rd(12'hFD5, 8'h20, 0, 0, "R9");
        rd(12'hFD6, 8'h01, 0, 0, "R9");
        // R2: other windows untouched
        rd(12'hFDD, 8'h00, 0, 0, "R2");
        rd(12'hFE5, 8'h00, 0, 0, "R2");
        // R12: plain pass-through and the spare slot
        wr(12'h120, 8'hA5, 1, 12'h120, "R12");
        rd(12'h120, 8'hA5, 1, 12'h120, "R12");
        wr(12'hFD7, 8'h3C, 1, 12'hFD7, "R12");
        rd(12'hFD7, 8'h3C, 1, 12'hFD7, "R12");
        // R3: plain indirect
        rd(12'hFD0, 8'hA5, 1, 12'h120, "R3");
        rd(12'hFD5, 8'h20, 0, 0, "R3");
        // R4: post-increment writes
        wr(12'hFD1, 8'h11, 1, 12'h120, "R4");
        wr(12'hFD1, 8'h22, 1, 12'h121, "R4");
        rd(12'hFD5, 8'h22, 0, 0, "R4");
        rd(12'h121, 8'h22, 1, 12'h121, "R4");
        // R5: post-decrement reads
        rd(12'hFD2, 8'h00, 1, 12'h122, "R5");
        rd(12'hFD2, 8'h22, 1, 12'h121, "R5");
        rd(12'hFD5, 8'h20, 0, 0, "R5");
        // R6: pre-increment
        rd(12'hFD3, 8'h22, 1, 12'h121, "R6");
        rd(12'hFD5, 8'h21, 0, 0, "R6");
        // R8: working register at 0xFE8
        wr(12'hFE8, 8'hFE, 0, 0, "R8");
        rd(12'hFE8, 8'hFE, 0, 0, "R8");
        // R7: plus-W with -2 then +127
        wr(12'hFD4, 8'h77, 1, 12'h11F, "R7");
        rd(12'hFD5, 8'h21, 0, 0, "R7");
        rd(12'h11F, 8'h77, 1, 12'h11F, "R7");
        wr(12'hFE8, 8'h7F, 0, 0, "R8");
        rd(12'hFD4, 8'h00, 1, 12'h1A0, "R7");
        // R10 / R5: wrap of pointer 1 at both ends
        rd(12'hFDA, 8'h00, 1, 12'h000, "R5");
        rd(12'hFDD, 8'hFF, 0, 0, "R10");
        rd(12'hFDE, 8'hFF, 0, 0, "R10");
        rd(12'hFD9, 8'h00, 1, 12'hFFF, "R10");
        rd(12'hFDE, 8'h00, 0, 0, "R10");
        rd(12'hFDD, 8'h00, 0, 0, "R10");
        wr(12'hFDD, 8'h56, 0, 0, "R9");
        wr(12'hFDE, 8'h34, 0, 0, "R9");
        rd(12'hFD8, 8'h00, 1, 12'h456, "R10");
        // R11: pointer 2 aimed at pointer 0's post-increment slot
        wr(12'hFE5, 8'hD1, 0, 0, "R9");
        wr(12'hFE6, 8'h0F, 0, 0, "R9");
        rd(12'hFE1, 8'h00, 0, 0, "R11");
        rd(12'hFE5, 8'hD1, 0, 0, "R11");
        rd(12'hFD5, 8'h21, 0, 0, "R11");
        wr(12'hFE0, 8'h55, 0, 0, "R11");
        wr(12'hFE5, 8'hD0, 0, 0, "R9");
        wr(12'hFE6, 8'h1F, 0, 0, "R9");
        rd(12'hFE2, 8'h00, 0, 0, "R11");
        rd(12'hFE5, 8'hD0, 0, 0, "R11");
        rd(12'hFE6, 8'h1F, 0, 0, "R11");
        // R2 / R6: pointer 2 pre-increment into real memory
        wr(12'hFE5, 8'h00, 0, 0, "R9");
        wr(12'hFE6, 8'h02, 0, 0, "R9");
        rd(12'hFE3, 8'h00, 1, 12'h201, "R2");
        rd(12'hFE5, 8'h01, 0, 0, "R6");
        idle();
        repeat (3) @(posedge clk);
        check(q.size() == 0, "SB", "queue drained", q.size(), 0);
        finish_run();
    end

endmodule